// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel

This block is one DMA channel. It copies data from a source address to a target address over a single memory master port, which carries both descriptor traffic and data traffic. Software programs the channel through a four-word register window. The window holds a link word (the next-descriptor pointer), a source pointer, a target pointer and a command word. A start pulse then either loads a 16-byte descriptor from memory into those four registers, or, when fetching is disabled, runs directly from the values already programmed.

A transfer is split into bursts. Within each burst, every read is done before any write, and the remaining byte count is written back into the command word after the burst. The command word can ask for pacing by an external request line. When that line has dropped by the end of a burst, the channel reports end-of-receive. It can then halt, or jump to the next descriptor. When the count reaches zero, the channel follows the link word to the next descriptor, unless the link is marked as the last one or fetching is disabled. A compare-status input can redirect a fetch to an alternate descriptor 32 bytes further on. The channel reports start, end, stop and end-of-receive as one-cycle pulses.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the channel is idle: `busy_o`, `err_o`, `mem_req_o` and all event pulses are low, and all four window registers read zero.
- R2: Window select 0 is the link word, 1 the source pointer, 2 the target pointer and 3 the command word. Reads are combinational. Writes take effect only while idle and are ignored while `busy_o` is high.
- R3: A start with `nofetch_i` low performs four word reads (size code 3), in the order link, source, target, command. They start at the link word with its low 4 bits cleared, plus 32 when link bit 1 and `cmp_i` are both set. Command bit 22 raises a start pulse once the fetch completes.
- R4: Command bits 15:14 select the access width: code 1 is 1 byte, code 2 is 2 bytes, code 3 is 4 bytes. Code 0 is reserved. Code 0 sets `err_o`, pulses stop and returns to idle with no data access. The next start clears `err_o`.
- R5: Command bits 17:16 code c give a burst of 4<<c bytes. Each burst moves the smaller of the burst size and the remaining length (bits 12:0). All reads of a burst come before its writes. The reduced length is written back into bits 12:0.
- R6: Command bit 31 advances the source pointer by the width after each read, and bit 30 advances the target pointer after each write. A clear bit keeps that pointer fixed.
- R7: Command bit 29 (source paced) or bit 28 (target paced) holds each burst until `flow_req_i` is high. Loading such a command clears the low 2 bits of the matching pointer.
- R8: Under pacing, if `flow_req_i` is low when a burst ends, an end-of-receive pulse is raised. With `eor_stop_i` high the channel also pulses stop and goes idle, keeping the remaining length.
- R9: On end-of-receive with `eor_stop_i` low, `eor_jump_i` high and `nofetch_i` low, the channel fetches the descriptor named by the link word.
- R10: When the length reaches zero, command bit 21 raises an end pulse. If link bit 0 is set or `nofetch_i` is high, stop pulses and the channel goes idle. Otherwise the linked descriptor is fetched.
- R11: A start with `nofetch_i` high transfers from the programmed window registers without any descriptor read.
- R12: An access that is not yet accepted by `mem_ready_i` keeps `mem_req_o`, `mem_we_o` and `mem_addr_o` unchanged until it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, honoured when idle |
| nofetch_i | input | 1 | Run from window registers, no descriptor reads |
| eor_stop_i | input | 1 | Halt on end-of-receive |
| eor_jump_i | input | 1 | Fetch next descriptor on end-of-receive |
| cmp_i | input | 1 | Compare status for branch fetch |
| flow_req_i | input | 1 | Pacing request |
| win_we_i | input | 1 | Window write strobe |
| win_sel_i | input | 2 | Window register select |
| win_wdata_i | input | 32 | Window write data |
| win_rdata_o | output | 32 | Window read data |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_size_o | output | 2 | Access width code |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data, low-aligned |
| mem_rdata_i | input | 32 | Read data, low-aligned |
| mem_ready_i | input | 1 | Access accepted this cycle |
| busy_o | output | 1 | Channel active |
| err_o | output | 1 | Reserved width seen |
| ev_start_o | output | 1 | Start event pulse |
| ev_end_o | output | 1 | End event pulse |
| ev_stop_o | output | 1 | Stop event pulse |
| ev_eor_o | output | 1 | End-of-receive pulse |

## Verification
The assertions assume that the memory side answers only a pending request, and that `mem_rdata_i` is meaningful only in the cycle of a read acceptance. The stimulus keeps to this: its memory model raises ready only against a live request, and stalls on a fixed pattern. The assertions also assume that window writes and start pulses are driven away from the clock edge. Pacing changes happen at negative edges, timed against observed write acceptances, so the request level seen at a burst's last write is known in advance.

// File: rtl/dmae_pkg.sv
package dmae_pkg;

    localparam int WORD_W   = 32;
    localparam int LEN_W    = 13;
    localparam int SEL_W    = 2;

    // command word bit positions (decoded by the engine)
    localparam int CMD_INC_SRC  = 31;
    localparam int CMD_INC_DST  = 30;
    localparam int CMD_PACE_SRC = 29;
    localparam int CMD_PACE_DST = 28;
    localparam int CMD_EV_START = 22;
    localparam int CMD_EV_END   = 21;
    localparam int CMD_BSZ_LO   = 16;
    localparam int CMD_WID_LO   = 14;

    // link word bit positions
    localparam int LNK_LAST   = 0;
    localparam int LNK_BRANCH = 1;

    localparam logic [1:0] SIZE_WORD = 2'd3;

    typedef enum logic [4:0] {
        ST_IDLE  = 5'b00001,
        ST_FETCH = 5'b00010,
        ST_READ  = 5'b00100,
        ST_WRITE = 5'b01000,
        ST_DONE  = 5'b10000
    } dma_state_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_LINK = 2'd0,
        SEL_SRC  = 2'd1,
        SEL_DST  = 2'd2,
        SEL_CMD  = 2'd3
    } win_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] link;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] cmd;
    } chan_regs_t;

    typedef struct packed {
        logic             fetch_ld;
        logic [SEL_W-1:0] fetch_idx;
        logic             src_adv;
        logic             dst_adv;
        logic             len_ld;
    } reg_upd_t;

    typedef struct packed {
        logic start;
        logic fin;
        logic stop;
        logic eor;
    } dma_ev_t;

    function automatic logic [LEN_W-1:0] width_bytes(input logic [1:0] code);
        case (code)
            2'd1:    return LEN_W'(1);
            2'd2:    return LEN_W'(2);
            2'd3:    return LEN_W'(4);
            default: return '0;
        endcase
    endfunction

    function automatic logic [1:0] width_log(input logic [1:0] code);
        return (code == 2'd0) ? 2'd0 : code - 2'd1;
    endfunction

    function automatic logic [LEN_W-1:0] burst_bytes(input logic [1:0] code);
        return LEN_W'(4) << code;
    endfunction

endpackage

// File: rtl/dmae_regs.sv
module dmae_regs
    import dmae_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic              win_we_i,
    input  logic [SEL_W-1:0]  win_sel_i,
    input  logic [WORD_W-1:0] win_wdata_i,
    output logic [WORD_W-1:0] win_rdata_o,
    input  reg_upd_t          upd_i,
    input  logic [WORD_W-1:0] ld_data_i,
    input  logic [LEN_W-1:0]  len_new_i,
    output chan_regs_t        regs_o
);

    chan_regs_t regs_q;
    logic [WORD_W-1:0] step;

    assign step   = WORD_W'(width_bytes(regs_q.cmd[CMD_WID_LO +: 2]));
    assign regs_o = regs_q;

    always_comb begin
        case (win_sel_e'(win_sel_i))
            SEL_LINK: win_rdata_o = regs_q.link;
            SEL_SRC:  win_rdata_o = regs_q.src;
            SEL_DST:  win_rdata_o = regs_q.dst;
            default:  win_rdata_o = regs_q.cmd;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            if (!busy_i && win_we_i) begin
                case (win_sel_e'(win_sel_i))
                    SEL_LINK: regs_q.link <= win_wdata_i;
                    SEL_SRC:  regs_q.src  <= win_wdata_i;
                    SEL_DST:  regs_q.dst  <= win_wdata_i;
                    default:  regs_q.cmd  <= win_wdata_i;
                endcase
            end
            if (upd_i.fetch_ld) begin
                case (win_sel_e'(upd_i.fetch_idx))
                    SEL_LINK: regs_q.link <= ld_data_i;
                    SEL_SRC:  regs_q.src  <= ld_data_i;
                    SEL_DST:  regs_q.dst  <= ld_data_i;
                    default: begin
                        regs_q.cmd <= ld_data_i;
                        if (ld_data_i[CMD_PACE_SRC]) regs_q.src[1:0] <= 2'b00;
                        if (ld_data_i[CMD_PACE_DST]) regs_q.dst[1:0] <= 2'b00;
                    end
                endcase
            end
            if (upd_i.src_adv && regs_q.cmd[CMD_INC_SRC])
                regs_q.src <= regs_q.src + step;
            if (upd_i.dst_adv && regs_q.cmd[CMD_INC_DST])
                regs_q.dst <= regs_q.dst + step;
            if (upd_i.len_ld)
                regs_q.cmd[LEN_W-1:0] <= len_new_i;
        end
    end

    // R2
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i && win_we_i && !upd_i.fetch_ld && !upd_i.src_adv &&
        !upd_i.dst_adv && !upd_i.len_ld |=> $stable(regs_q));

    // R7
    pace_mask_chk: assert property (@(posedge clk) disable iff (rst)
        upd_i.fetch_ld && upd_i.fetch_idx == 2'd3 && ld_data_i[CMD_PACE_SRC]
        |=> regs_q.src[1:0] == 2'b00);

endmodule

// File: rtl/dmae_buf.sv
module dmae_buf #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [W-1:0]     wr_data_i,
    output logic [W-1:0]     rd_data_o
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) mem_q[idx_i] <= wr_data_i;
    end

    assign rd_data_o = mem_q[idx_i];

endmodule

// File: rtl/dmae_ctrl.sv
module dmae_ctrl
    import dmae_pkg::*;
#(
    parameter int MAX_BURST = 32,
    localparam int IDX_W = $clog2(MAX_BURST)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              nofetch_i,
    input  logic              eor_stop_i,
    input  logic              eor_jump_i,
    input  logic              cmp_i,
    input  logic              flow_req_i,
    input  chan_regs_t        regs_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [1:0]        mem_size_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output reg_upd_t          upd_o,
    output logic [LEN_W-1:0]  len_new_o,
    output logic              buf_wr_o,
    output logic [IDX_W-1:0]  buf_idx_o,
    output logic              busy_o,
    output logic              err_o,
    output dma_ev_t           ev_o
);

    dma_state_e state_q, state_d;
    logic [LEN_W-1:0]  beat_q, beat_d;
    logic [WORD_W-1:0] fetch_base_q, fetch_next;
    logic              fetch_load;
    logic              err_q, err_d;
    logic              pend_q;
    dma_ev_t           ev_q, ev_d;

    logic [1:0]       wcode;
    logic [LEN_W-1:0] wb, len, bsz, burst, nbeats, len_new;
    logic             paced, stall, last_beat, accept, eor_hit;

    assign wcode   = regs_i.cmd[CMD_WID_LO +: 2];
    assign wb      = width_bytes(wcode);
    assign len     = regs_i.cmd[LEN_W-1:0];
    assign bsz     = burst_bytes(regs_i.cmd[CMD_BSZ_LO +: 2]);
    assign burst   = (len < bsz) ? len : bsz;
    assign nbeats  = (burst + wb - LEN_W'(1)) >> width_log(wcode);
    assign len_new = len - burst;
    assign paced   = regs_i.cmd[CMD_PACE_SRC] | regs_i.cmd[CMD_PACE_DST];
    assign eor_hit = paced && !flow_req_i;
    assign stall   = (state_q == ST_READ) && (beat_q == '0) && eor_hit && !pend_q;
    assign last_beat = (beat_q == nbeats - LEN_W'(1));

    assign fetch_next = {regs_i.link[WORD_W-1:4], 4'b0000} +
                        ((regs_i.link[LNK_BRANCH] && cmp_i) ? WORD_W'(32) : '0);

    always_comb begin
        mem_req_o  = (state_q == ST_FETCH) || (state_q == ST_WRITE) ||
                     ((state_q == ST_READ) && !stall);
        mem_we_o   = (state_q == ST_WRITE);
        mem_size_o = (state_q == ST_FETCH) ? SIZE_WORD : wcode;
        case (state_q)
            ST_FETCH: mem_addr_o = fetch_base_q + {{(WORD_W-4){1'b0}}, beat_q[1:0], 2'b00};
            ST_WRITE: mem_addr_o = regs_i.dst;
            default:  mem_addr_o = regs_i.src;
        endcase
    end

    assign accept    = mem_req_o && mem_ready_i;
    assign buf_idx_o = beat_q[IDX_W-1:0];
    assign len_new_o = len_new;

    always_comb begin
        state_d    = state_q;
        beat_d     = beat_q;
        err_d      = err_q;
        ev_d       = '0;
        upd_o      = '0;
        buf_wr_o   = 1'b0;
        fetch_load = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    err_d  = 1'b0;
                    beat_d = '0;
                    if (!nofetch_i) begin
                        state_d    = ST_FETCH;
                        fetch_load = 1'b1;
                    end else if (wcode == 2'd0) begin
                        err_d     = 1'b1;
                        ev_d.stop = 1'b1;
                    end else begin
                        state_d = (len == '0) ? ST_DONE : ST_READ;
                    end
                end
            end
            ST_FETCH: begin
                if (accept) begin
                    upd_o.fetch_ld  = 1'b1;
                    upd_o.fetch_idx = beat_q[1:0];
                    if (beat_q[1:0] == 2'd3) begin
                        beat_d     = '0;
                        ev_d.start = mem_rdata_i[CMD_EV_START];
                        if (mem_rdata_i[CMD_WID_LO +: 2] == 2'd0) begin
                            err_d     = 1'b1;
                            ev_d.stop = 1'b1;
                            state_d   = ST_IDLE;
                        end else begin
                            state_d = (mem_rdata_i[LEN_W-1:0] == '0) ? ST_DONE : ST_READ;
                        end
                    end else begin
                        beat_d = beat_q + LEN_W'(1);
                    end
                end
            end
            ST_READ: begin
                if (accept) begin
                    buf_wr_o      = 1'b1;
                    upd_o.src_adv = 1'b1;
                    if (last_beat) begin
                        beat_d  = '0;
                        state_d = ST_WRITE;
                    end else begin
                        beat_d = beat_q + LEN_W'(1);
                    end
                end
            end
            ST_WRITE: begin
                if (accept) begin
                    upd_o.dst_adv = 1'b1;
                    if (last_beat) begin
                        beat_d       = '0;
                        upd_o.len_ld = 1'b1;
                        state_d      = (len_new == '0) ? ST_DONE : ST_READ;
                        if (eor_hit) begin
                            ev_d.eor = 1'b1;
                            if (eor_stop_i) begin
                                ev_d.stop = 1'b1;
                                state_d   = ST_IDLE;
                            end else if (eor_jump_i && !nofetch_i) begin
                                state_d    = ST_FETCH;
                                fetch_load = 1'b1;
                            end
                        end
                    end else begin
                        beat_d = beat_q + LEN_W'(1);
                    end
                end
            end
            ST_DONE: begin
                ev_d.fin = regs_i.cmd[CMD_EV_END];
                if (regs_i.link[LNK_LAST] || nofetch_i) begin
                    ev_d.stop = 1'b1;
                    state_d   = ST_IDLE;
                end else begin
                    state_d    = ST_FETCH;
                    fetch_load = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            beat_q       <= '0;
            fetch_base_q <= '0;
            err_q        <= 1'b0;
            pend_q       <= 1'b0;
            ev_q         <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            err_q   <= err_d;
            pend_q  <= mem_req_o && !mem_ready_i;
            ev_q    <= ev_d;
            if (fetch_load) fetch_base_q <= fetch_next;
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign err_o  = err_q;
    assign ev_o   = ev_q;

    // R12
    access_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mem_req_o);

    // R3
    fetch_read_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_FETCH |-> !mem_we_o && mem_size_o == SIZE_WORD);

    // R4
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !busy_o);

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ev_o.stop |-> !busy_o);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dmae_pkg::*;
#(
    parameter int MAX_BURST_BYTES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        nofetch_i,
    input  logic        eor_stop_i,
    input  logic        eor_jump_i,
    input  logic        cmp_i,
    input  logic        flow_req_i,
    input  logic        win_we_i,
    input  logic [1:0]  win_sel_i,
    input  logic [31:0] win_wdata_i,
    output logic [31:0] win_rdata_o,
    output logic        mem_req_o,
    output logic        mem_we_o,
    output logic [1:0]  mem_size_o,
    output logic [31:0] mem_addr_o,
    output logic [31:0] mem_wdata_o,
    input  logic [31:0] mem_rdata_i,
    input  logic        mem_ready_i,
    output logic        busy_o,
    output logic        err_o,
    output logic        ev_start_o,
    output logic        ev_end_o,
    output logic        ev_stop_o,
    output logic        ev_eor_o
);

    localparam int IDX_W = $clog2(MAX_BURST_BYTES);

    chan_regs_t       regs;
    reg_upd_t         upd;
    logic [LEN_W-1:0] len_new;
    logic             buf_wr;
    logic [IDX_W-1:0] buf_idx;
    dma_ev_t          ev;

    dmae_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .busy_i     (busy_o),
        .win_we_i   (win_we_i),
        .win_sel_i  (win_sel_i),
        .win_wdata_i(win_wdata_i),
        .win_rdata_o(win_rdata_o),
        .upd_i      (upd),
        .ld_data_i  (mem_rdata_i),
        .len_new_i  (len_new),
        .regs_o     (regs)
    );

    dmae_ctrl #(.MAX_BURST(MAX_BURST_BYTES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .nofetch_i  (nofetch_i),
        .eor_stop_i (eor_stop_i),
        .eor_jump_i (eor_jump_i),
        .cmp_i      (cmp_i),
        .flow_req_i (flow_req_i),
        .regs_i     (regs),
        .mem_rdata_i(mem_rdata_i),
        .mem_ready_i(mem_ready_i),
        .mem_req_o  (mem_req_o),
        .mem_we_o   (mem_we_o),
        .mem_size_o (mem_size_o),
        .mem_addr_o (mem_addr_o),
        .upd_o      (upd),
        .len_new_o  (len_new),
        .buf_wr_o   (buf_wr),
        .buf_idx_o  (buf_idx),
        .busy_o     (busy_o),
        .err_o      (err_o),
        .ev_o       (ev)
    );

    dmae_buf #(.DEPTH(MAX_BURST_BYTES), .W(WORD_W)) u_buf (
        .clk      (clk),
        .wr_en_i  (buf_wr),
        .idx_i    (buf_idx),
        .wr_data_i(mem_rdata_i),
        .rd_data_o(mem_wdata_o)
    );

    assign ev_start_o = ev.start;
    assign ev_end_o   = ev.fin;
    assign ev_stop_o  = ev.stop;
    assign ev_eor_o   = ev.eor;

endmodule

// File: tb/sim_dma_chan_engine.sv
`timescale 1ns/1ps
module sim_dma_chan_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 0, nofetch_i = 0, eor_stop_i = 0, eor_jump_i = 0;
    logic        cmp_i = 0, flow_req_i = 0;
    logic        win_we_i = 0;
    logic [1:0]  win_sel_i = 0;
    logic [31:0] win_wdata_i = 0, win_rdata_o;
    logic        mem_req_o, mem_we_o;
    logic [1:0]  mem_size_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic [31:0] mem_rdata_i = 0;
    logic        mem_ready_i = 0;
    logic        busy_o, err_o, ev_start_o, ev_end_o, ev_stop_o, ev_eor_o;

    always #2.5 clk = ~clk;

    dma_chan_engine u0 (.*);

    int total = 0, bad = 0;
    int cyc = 0, wr_count = 0, hold_viol = 0;
    int n_start = 0, n_end = 0, n_stop = 0, n_eor = 0;
    logic [7:0] mem [1024];

    typedef struct packed { logic [31:0] a; logic [31:0] d; logic [1:0] s; } wr_t;
    wr_t exp_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int wbytes(input logic [1:0] c);
        return (c == 3) ? 4 : int'(c);
    endfunction

    function automatic logic [31:0] mrd(input logic [31:0] a, input int n);
        logic [31:0] v = 0;
        for (int i = 0; i < n; i++) v[8*i +: 8] = mem[(a + i) % 1024];
        return v;
    endfunction

    task automatic mwr(input logic [31:0] a, input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) mem[(a + i) % 1024] = v[8*i +: 8];
    endtask

    task automatic put_desc(input logic [31:0] at, lnk, s, d, c);
        mwr(at, lnk, 4); mwr(at + 4, s, 4); mwr(at + 8, d, 4); mwr(at + 12, c, 4);
    endtask

    // driver: push expected writes for up to max_b bursts
    task automatic plan(input logic [31:0] s0, d0, c, input int max_b);
        int w = wbytes(c[15:14]);
        int bsz = 4 << c[17:16];
        int len = int'(c[12:0]);
        int nb = 0;
        logic [31:0] s = s0, d = d0;
        logic [31:0] buffer [32];
        while (len > 0 && nb < max_b) begin
            int burst = (len < bsz) ? len : bsz;
            int beats = (burst + w - 1) / w;
            for (int k = 0; k < beats; k++) begin
                buffer[k] = mrd(s, w);
                if (c[31]) s += w;
            end
            for (int k = 0; k < beats; k++) begin
                exp_q.push_back({d, buffer[k], c[15:14]});
                if (c[30]) d += w;
            end
            len -= burst;
            nb++;
        end
    endtask

    // memory responder and monitor
    always @(negedge clk) begin
        logic rdy;
        cyc++;
        rdy = mem_req_o && (cyc % 3 != 1);
        if (hold_viol >= 0 && rst == 1'b0) begin end
        mem_ready_i = rdy;
        mem_rdata_i = 0;
        if (rdy && !mem_we_o) mem_rdata_i = mrd(mem_addr_o, wbytes(mem_size_o));
        if (rdy && mem_we_o) begin
            wr_t e;
            mwr(mem_addr_o, mem_wdata_o, wbytes(mem_size_o));
            wr_count++;
            if (exp_q.size() == 0) begin
                chk("R5 unexpected write addr", mem_addr_o, 32'hFFFF_FFFF);
            end else begin
                e = exp_q.pop_front();
                chk("R6 write address", mem_addr_o, e.a);
                chk("R5 write data", mem_wdata_o, e.d);
                chk("R4 write size", {30'b0, mem_size_o}, {30'b0, e.s});
            end
        end
        if (ev_start_o) n_start++;
        if (ev_end_o)   n_end++;
        if (ev_stop_o)  n_stop++;
        if (ev_eor_o)   n_eor++;
    end

    // R12 hold monitor
    logic        prev_wait = 0;
    logic [31:0] prev_addr = 0;
    always @(negedge clk) begin
        #0.5;
        if (prev_wait && !(mem_req_o && mem_addr_o == prev_addr)) hold_viol++;
        prev_wait = mem_req_o && !mem_ready_i;
        prev_addr = mem_addr_o;
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R10 watchdog act=running exp=finished");
        finish_run();
    end

    task automatic win_wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        win_we_i = 1; win_sel_i = sel; win_wdata_i = d;
        @(negedge clk);
        win_we_i = 0;
    endtask

    task automatic win_rd(input logic [1:0] sel, output logic [31:0] d);
        win_sel_i = sel;
        #1;
        d = win_rdata_o;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy_o && n < 5000) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        int s0, e0, t0, w0, r0;
        for (int i = 0; i < 1024; i++) mem[i] = (i >= 'h300) ? 8'(i * 7 + 3) : 8'h00;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'b0, busy_o}, 0);
        chk("R1 err", {31'b0, err_o}, 0);
        chk("R1 mem_req", {31'b0, mem_req_o}, 0);
        chk("R1 events", {28'b0, ev_start_o, ev_end_o, ev_stop_o, ev_eor_o}, 0);
        for (int s = 0; s < 4; s++) begin
            win_rd(2'(s), v);
            chk("R1 window zero", v, 0);
        end

        // R2 window map
        win_wr(0, 32'h1111_0000); win_wr(1, 32'h2222_0004);
        win_wr(2, 32'h3333_0008); win_wr(3, 32'h4444_000C);
        win_rd(0, v); chk("R2 link", v, 32'h1111_0000);
        win_rd(1, v); chk("R2 src", v, 32'h2222_0004);
        win_rd(2, v); chk("R2 dst", v, 32'h3333_0008);
        win_rd(3, v); chk("R2 cmd", v, 32'h4444_000C);

        // R11 direct run without fetch, R5 R6 R10
        win_wr(0, 0); win_wr(1, 32'h300); win_wr(2, 32'h080); win_wr(3, 32'hC021_C00C);
        plan(32'h300, 32'h080, 32'hC021_C00C, 99);
        s0 = n_stop; e0 = n_end; t0 = n_start;
        nofetch_i = 1;
        pulse_start();
        wait_idle();
        nofetch_i = 0;
        chk("R11 all writes seen", exp_q.size(), 0);
        chk("R10 end pulse", n_end - e0, 1);
        chk("R10 stop pulse", n_stop - s0, 1);
        chk("R11 no start pulse", n_start - t0, 0);
        win_rd(3, v); chk("R5 length written back", v, 32'hC021_C000);
        win_rd(1, v); chk("R6 src advanced", v, 32'h30C);
        win_rd(2, v); chk("R6 dst advanced", v, 32'h08C);

        // R3 fetch and R10 chaining
        put_desc(32'h100, 32'h110, 32'h310, 32'h0A0, 32'hC040_8006);
        put_desc(32'h110, 32'h001, 32'h320, 32'h0B0, 32'h4061_4005);
        plan(32'h310, 32'h0A0, 32'hC040_8006, 99);
        plan(32'h320, 32'h0B0, 32'h4061_4005, 99);
        s0 = n_stop; e0 = n_end; t0 = n_start;
        win_wr(0, 32'h100);
        pulse_start();
        wait_idle();
        chk("R10 chain writes seen", exp_q.size(), 0);
        chk("R3 start pulses", n_start - t0, 2);
        chk("R10 end pulse once", n_end - e0, 1);
        chk("R10 stop once", n_stop - s0, 1);
        win_rd(0, v); chk("R3 link loaded", v, 32'h001);
        win_rd(1, v); chk("R6 fixed src", v, 32'h320);

        // R3 branch fetch
        put_desc(32'h200, 32'h001, 32'h330, 32'h0E0, 32'hC001_C004);
        put_desc(32'h220, 32'h001, 32'h338, 32'h0D0, 32'hC001_C008);
        plan(32'h338, 32'h0D0, 32'hC001_C008, 99);
        w0 = wr_count;
        cmp_i = 1;
        win_wr(0, 32'h202);
        pulse_start();
        wait_idle();
        chk("R3 branch target used", wr_count - w0, 2);
        chk("R3 branch writes match", exp_q.size(), 0);
        plan(32'h330, 32'h0E0, 32'hC001_C004, 99);
        w0 = wr_count;
        cmp_i = 0;
        win_wr(0, 32'h202);
        pulse_start();
        wait_idle();
        chk("R3 no branch without compare", wr_count - w0, 1);
        chk("R3 plain writes match", exp_q.size(), 0);

        // R7 pacing, R8 stop on end-of-receive, R2 busy write ignored
        put_desc(32'h240, 32'h250, 32'h343, 32'h000, 32'hE001_C018);
        win_wr(0, 32'h240);
        flow_req_i = 0; eor_stop_i = 1;
        s0 = n_stop; r0 = n_eor; w0 = wr_count;
        pulse_start();
        repeat (30) @(negedge clk);
        chk("R7 waits for request busy", {31'b0, busy_o}, 1);
        chk("R7 no data access", wr_count - w0, 0);
        chk("R7 no request while waiting", {31'b0, mem_req_o}, 0);
        win_wr(1, 32'hDEAD_0000);
        win_rd(1, v); chk("R7 src masked, R2 busy write ignored", v, 32'h340);
        plan(32'h340, 32'h000, 32'hE001_C018, 1);
        flow_req_i = 1;
        while (wr_count == w0) @(negedge clk);
        flow_req_i = 0;
        wait_idle();
        eor_stop_i = 0;
        chk("R8 one burst only", exp_q.size(), 0);
        chk("R8 eor pulse", n_eor - r0, 1);
        chk("R8 stop pulse", n_stop - s0, 1);
        win_rd(3, v); chk("R8 remaining length", v, 32'hE001_C010);
        win_rd(1, v); chk("R8 src after burst", v, 32'h348);

        // R9 jump on end-of-receive
        put_desc(32'h280, 32'h290, 32'h350, 32'h020, 32'hD001_C010);
        put_desc(32'h290, 32'h001, 32'h360, 32'h030, 32'hC021_C004);
        plan(32'h350, 32'h020, 32'hD001_C010, 1);
        plan(32'h360, 32'h030, 32'hC021_C004, 99);
        win_wr(0, 32'h280);
        flow_req_i = 1; eor_jump_i = 1;
        s0 = n_stop; r0 = n_eor; e0 = n_end; w0 = wr_count;
        pulse_start();
        while (wr_count == w0) @(negedge clk);
        flow_req_i = 0;
        wait_idle();
        eor_jump_i = 0;
        chk("R9 jump writes", exp_q.size(), 0);
        chk("R9 eor pulse", n_eor - r0, 1);
        chk("R9 end of jumped descriptor", n_end - e0, 1);
        win_rd(2, v); chk("R9 dst of jumped descriptor", v, 32'h034);

        // R4 reserved width
        put_desc(32'h2A0, 32'h001, 32'h370, 32'h040, 32'hC001_0004);
        win_wr(0, 32'h2A0);
        s0 = n_stop; w0 = wr_count;
        pulse_start();
        wait_idle();
        chk("R4 err set", {31'b0, err_o}, 1);
        chk("R4 stop pulse", n_stop - s0, 1);
        chk("R4 no data", wr_count - w0, 0);

        // R10 zero length, R4 err cleared by next start
        win_wr(3, 32'hC020_C000);
        nofetch_i = 1;
        s0 = n_stop; e0 = n_end; w0 = wr_count;
        pulse_start();
        wait_idle();
        nofetch_i = 0;
        chk("R4 err cleared", {31'b0, err_o}, 0);
        chk("R10 zero length end", n_end - e0, 1);
        chk("R10 zero length stop", n_stop - s0, 1);
        chk("R10 zero length no data", wr_count - w0, 0);

        chk("R12 access held until ready", hold_viol, 0);
        finish_run();
    end

endmodule